// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block sits between a CPU core and the pins of a separate (non-multiplexed) external bus with zero wait states. The core presents one memory request per bus-clock cycle: a valid flag, an address and a read/write flag. The block classifies each request as a hit on one of four external areas, an internal-memory access, or an empty cycle with no access and no prefetch. From that class it drives the external address bus, four active-low chip-select lines and an active-low read strobe.

The address bus and chip selects are not simply re-driven every cycle. They follow hold rules. A chip select stays low across back-to-back hits on its own area. An internal access releases the chip select but leaves the last external address on the pins. An empty cycle freezes both. Because of these rules, one chip-select assertion can span many consecutive cycles.

The four external areas are set by base and size values on input ports. Each value is counted in units of the address field made of the top `DEC_W` address bits. A small state machine tracks what the bus last did. Its states are:
- `S_IDLE`: no chip select is asserted and nothing is held.
- `S_EXT`: a chip select is asserted or held.
- `S_INT`: the last access went to internal memory.

Its transitions are:
- Any state goes to `S_EXT` on an external hit.
- Any state goes to `S_INT` on an internal access.
- `S_EXT` stays in `S_EXT` on an empty cycle. This is the hold transition.
- `S_INT` and `S_IDLE` go to `S_IDLE` on an empty cycle.

Top module: `bus_cs_ctrl`

## Requirements
- R1: While reset is low and after it is released with no request, `cs_n` is all ones, `rd_n` is 1 and `ext_addr` is zero.
- R2: Area k is hit when the address field `req_addr[ADDR_W-1 -: DEC_W]` satisfies base_k <= field < base_k + size_k. Base_k is in bits `[DEC_W*k +: DEC_W]` of `area_base`, and size_k is in the same bits of `area_size`. When areas overlap, the lowest index wins. A field below `INT_TOP`, or one that hits no area, is an internal access.
- R3: At most one bit of `cs_n` is low in any cycle.
- R4: After an external hit on area j that follows any other kind of cycle or area, `ext_addr` equals that request's address. Also, `cs_n` has only bit j low.
- R5: After a hit on area i that follows a hit on the same area i, `cs_n` stays unchanged with bit i low, and `ext_addr` takes the new address.
- R6: After an internal access, `cs_n` is all ones and `ext_addr` keeps its previous value.
- R7: After a cycle with `req_valid` low, `cs_n` and `ext_addr` keep their previous values.
- R8: `rd_n` is low exactly in the cycle after an external read (`req_write`=0). It is high after a write, an internal access or an empty cycle.
- R9: Every output change becomes visible one bus-clock edge after the request is sampled, and only at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle (0 = empty cycle, no prefetch) |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Request address |
| area_base | input | NUM_AREAS*DEC_W | Per-area base field, area k in bits [DEC_W*k +: DEC_W] |
| area_size | input | NUM_AREAS*DEC_W | Per-area size in field units, 0 disables the area |
| ext_addr | output | ADDR_W | External address bus |
| cs_n | output | NUM_AREAS | Active-low chip selects, bit k for area k |
| rd_n | output | 1 | Active-low read strobe |

## Verification
The assertions check the following on every cycle against the decoder's classification:
- At most one chip select is low.
- An empty cycle freezes the pins.
- An internal access releases every select and keeps the address.
- An external hit loads the address.
- A repeated area leaves `cs_n` untouched.
- The read strobe matches the previous cycle's external read.

The bench's sweep makes a separate check: that the decoder itself places each address field in the right area. This includes overlap priority, the internal window and unmapped fields. The sweep drives every ordered pair of request kinds through the block and compares the pins against an arithmetic model. The sweep also checks long same-area runs with interleaved empty cycles and the exact cycle where outputs move.

// File: rtl/bus_cs_pkg.sv
package bus_cs_pkg;

    // Classification of one request by the area decoder
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,   // no access, no prefetch
        ACC_INT  = 2'd1,   // internal memory (or unmapped)
        ACC_EXT  = 2'd2    // one of the external areas
    } acc_kind_e;

    // Bus tracking state
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,     // nothing asserted
        S_EXT  = 2'd1,     // a chip select is asserted / held
        S_INT  = 2'd2      // last access was internal
    } bus_state_e;

endpackage

// File: rtl/bus_area_decoder.sv
module bus_area_decoder
    import bus_cs_pkg::*;
#(
    parameter int DEC_W     = 4,
    parameter int NUM_AREAS = 4,
    parameter int INT_TOP   = 1,
    localparam int IDX_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
    input  logic                         valid,
    input  logic [DEC_W-1:0]             field,
    input  logic [NUM_AREAS*DEC_W-1:0]   base_flat,
    input  logic [NUM_AREAS*DEC_W-1:0]   size_flat,
    output acc_kind_e                    kind,
    output logic [IDX_W-1:0]             area_idx
);

    logic [NUM_AREAS-1:0] hit;

    // One range comparator per area; one extra bit so base+size cannot wrap
    generate
        for (genvar k = 0; k < NUM_AREAS; k++) begin : g_area
            logic [DEC_W:0] lo;
            logic [DEC_W:0] hi;
            logic [DEC_W:0] fx;
            assign lo = {1'b0, base_flat[DEC_W*k +: DEC_W]};
            assign hi = lo + {1'b0, size_flat[DEC_W*k +: DEC_W]};
            assign fx = {1'b0, field};
            assign hit[k] = (fx >= lo) && (fx < hi);
        end
    endgenerate

    logic             any_hit;
    logic [IDX_W-1:0] pick;

    // Lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        any_hit = 1'b0;
        pick    = '0;
        for (int k = NUM_AREAS - 1; k >= 0; k--) begin
            if (hit[k]) begin
                any_hit = 1'b1;
                pick    = IDX_W'(k);
            end
        end
    end

    logic in_internal;
    assign in_internal = ({1'b0, field} < (DEC_W+1)'(INT_TOP));

    always_comb begin
        area_idx = pick;
        if (!valid)
            kind = ACC_NONE;
        else if (in_internal || !any_hit)
            kind = ACC_INT;
        else
            kind = ACC_EXT;
    end

endmodule

// File: rtl/bus_cs_fsm.sv
module bus_cs_fsm
    import bus_cs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int NUM_AREAS = 4,
    localparam int IDX_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  acc_kind_e             kind,
    input  logic [IDX_W-1:0]      area_idx,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  write,
    output logic [ADDR_W-1:0]     ext_addr,
    output logic [NUM_AREAS-1:0]  cs_n,
    output logic                  rd_n
);

    bus_state_e state, nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_INT: begin
                if (kind == ACC_EXT)      nxt = S_EXT;
                else if (kind == ACC_INT) nxt = S_INT;
                else                      nxt = S_IDLE;
            end
            S_EXT: begin
                if (kind == ACC_INT)      nxt = S_INT;
                else                      nxt = S_EXT;   // same/other area or hold
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Registered pin drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_addr <= '0;
            cs_n     <= '1;
            rd_n     <= 1'b1;
        end else begin
            rd_n <= 1'b1;
            unique case (nxt)
                S_EXT: begin
                    if (kind == ACC_EXT) begin
                        ext_addr <= addr;
                        cs_n     <= ~(NUM_AREAS'(1) << area_idx);
                        rd_n     <= write;
                    end
                end
                S_INT:   cs_n <= '1;
                S_IDLE:  cs_n <= '1;
                default: cs_n <= '1;
            endcase
        end
    end

endmodule

// File: rtl/bus_cs_ctrl.sv
module bus_cs_ctrl
    import bus_cs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DEC_W     = 4,
    parameter int NUM_AREAS = 4,
    parameter int INT_TOP   = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [NUM_AREAS*DEC_W-1:0]   area_base,
    input  logic [NUM_AREAS*DEC_W-1:0]   area_size,
    output logic [ADDR_W-1:0]            ext_addr,
    output logic [NUM_AREAS-1:0]         cs_n,
    output logic                         rd_n
);

    localparam int IDX_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1;

    acc_kind_e        dec_kind;
    logic [IDX_W-1:0] dec_area;

    bus_area_decoder #(
        .DEC_W     (DEC_W),
        .NUM_AREAS (NUM_AREAS),
        .INT_TOP   (INT_TOP)
    ) u_dec (
        .valid     (req_valid),
        .field     (req_addr[ADDR_W-1 -: DEC_W]),
        .base_flat (area_base),
        .size_flat (area_size),
        .kind      (dec_kind),
        .area_idx  (dec_area)
    );

    bus_cs_fsm #(
        .ADDR_W    (ADDR_W),
        .NUM_AREAS (NUM_AREAS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (dec_kind),
        .area_idx  (dec_area),
        .addr      (req_addr),
        .write     (req_write),
        .ext_addr  (ext_addr),
        .cs_n      (cs_n),
        .rd_n      (rd_n)
    );

endmodule

// File: rtl/bus_cs_chk.sv
module bus_cs_chk
    import bus_cs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int NUM_AREAS = 4,
    localparam int IDX_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_write,
    input logic [ADDR_W-1:0]     req_addr,
    input acc_kind_e             dec_kind,
    input logic [IDX_W-1:0]      dec_area,
    input logic [ADDR_W-1:0]     ext_addr,
    input logic [NUM_AREAS-1:0]  cs_n,
    input logic                  rd_n
);

    // Cycles since reset, saturating at 2, gates every $past use
    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (!rst_n)          seen <= 2'd0;
        else if (seen != 2'd2) seen <= seen + 2'd1;
    end

    // R3
    onehot_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4
    ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && $past(dec_kind) == ACC_EXT)
        |-> (ext_addr == $past(req_addr) && $countones(~cs_n) == 1));

    // R5
    same_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd2 && $past(dec_kind) == ACC_EXT && $past(dec_kind, 2) == ACC_EXT
         && $past(dec_area) == $past(dec_area, 2))
        |-> $stable(cs_n));

    // R6
    int_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && $past(dec_kind) == ACC_INT)
        |-> (&cs_n && ext_addr == $past(ext_addr)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && $past(dec_kind) == ACC_NONE)
        |-> ($stable(cs_n) && $stable(ext_addr)));

    // R8
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0)
        |-> (rd_n == !($past(dec_kind) == ACC_EXT && !$past(req_write))));

endmodule

bind bus_cs_ctrl bus_cs_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_AREAS (NUM_AREAS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_write (req_write),
    .req_addr  (req_addr),
    .dec_kind  (dec_kind),
    .dec_area  (dec_area),
    .ext_addr  (ext_addr),
    .cs_n      (cs_n),
    .rd_n      (rd_n)
);

// File: tb/bus_cs_ctrl_tb.sv
module bus_cs_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int DEC_W      = 4;
    localparam int NA         = 4;
    localparam int INT_TOP    = 1;
    localparam int NOPS       = 33;   // 16 fields x {read,write} + empty

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [NA*DEC_W-1:0] area_base, area_size;
    logic [ADDR_W-1:0] ext_addr;
    logic [NA-1:0]     cs_n;
    logic              rd_n;

    int n_cmp = 0;
    int n_bad = 0;

    // Model state
    logic [ADDR_W-1:0] m_addr;
    logic [NA-1:0]     m_cs;
    logic              m_rd;
    int                m_last;   // area of previous op, -1 internal, -2 empty

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cs_ctrl #(.ADDR_W(ADDR_W), .DEC_W(DEC_W), .NUM_AREAS(NA), .INT_TOP(INT_TOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .area_base(area_base), .area_size(area_size),
        .ext_addr(ext_addr), .cs_n(cs_n), .rd_n(rd_n));

    // Area numbers for a field: R2 rule computed from the base/size table
    function automatic int area_of(input int f);
        int bases [NA] = '{2, 4, 8, 10};
        int sizes [NA] = '{2, 4, 3, 6};
        if (f < INT_TOP) return -1;
        for (int k = 0; k < NA; k++)
            if (f >= bases[k] && f < bases[k] + sizes[k]) return k;
        return -1;
    endfunction

    task automatic check(input string tag);
        n_cmp++;
        if (ext_addr !== m_addr || cs_n !== m_cs || rd_n !== m_rd) begin
            n_bad++;
            $display("FAIL %s: addr=%h cs_n=%b rd_n=%b expected addr=%h cs_n=%b rd_n=%b",
                     tag, ext_addr, cs_n, rd_n, m_addr, m_cs, m_rd);
        end
    endtask

    // code < 32: field = code>>1, write = code&1; code 32 = empty cycle
    task automatic op(input int code, input logic [15:0] low);
        int    ar;
        string tag;
        @(negedge clk);
        req_valid = (code != 32);
        req_write = code[0];
        req_addr  = {4'(code >> 1), low};
        // expected state after the next rising edge (R9: one edge of latency)
        m_rd = 1'b1;
        if (code == 32) begin
            tag = "R7 R8 R9";
            m_last = (m_last >= 0) ? m_last : -2;
        end else begin
            ar = area_of(code >> 1);
            if (ar < 0) begin
                tag = "R6 R2 R8";
                m_cs = '1;
                m_last = -1;
            end else begin
                tag = (m_last == ar) ? "R5 R2 R8" : "R4 R2 R8";
                m_addr = req_addr;
                m_cs   = ~(NA'(1) << ar);
                m_rd   = code[0];
                m_last = ar;
            end
        end
        // just before the edge, outputs must still show the previous state (R9)
        #(CLK_PERIOD/2 - 1);
        @(posedge clk);
        #1;
        check(tag);
        n_cmp++;
        if (!$onehot0(~cs_n)) begin
            n_bad++;
            $display("FAIL R3: cs_n=%b expected at most one low", cs_n);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        area_base = {4'd10, 4'd8, 4'd4, 4'd2};
        area_size = {4'd6,  4'd3, 4'd4, 4'd2};
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        m_addr = '0; m_cs = '1; m_rd = 1'b1; m_last = -2;
        repeat (3) @(posedge clk);
        #1 check("R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check("R1 after release");
        op(32, 16'h0); op(32, 16'h0);

        // R9 explicit: outputs unchanged until the rising edge after sampling
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = {4'd5, 16'h1234};
        #1;
        n_cmp++;
        if (cs_n !== 4'hF || rd_n !== 1'b1) begin
            n_bad++;
            $display("FAIL R9: cs_n=%b rd_n=%b expected 1111 1 before edge", cs_n, rd_n);
        end
        @(posedge clk); #1;
        m_addr = {4'd5, 16'h1234}; m_cs = 4'b1101; m_rd = 1'b0; m_last = 1;
        check("R9 R4 after edge");

        // Exhaustive ordered pairs of request kinds
        for (int a = 0; a < NOPS; a++)
            for (int b = 0; b < NOPS; b++) begin
                op(a, 16'(a * 613 + b * 97 + 1));
                op(b, 16'(b * 389 + a * 31 + 7));
            end

        // Long same-area chains with interleaved empty cycles (R5, R7)
        for (int k = 0; k < 16; k++) begin
            op(12, 16'(k * 3 + 1));
            op(32, 16'h0);
            op(13, 16'(k * 5 + 2));
        end
        op(2, 16'h00AA);   // internal release (R6)
        op(32, 16'h0);     // empty after internal (R7)

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule